// File: doc/BRIEF.md
# Configurable GPIO Port with Edge Interrupts

This block is a general-purpose I/O port of `WIDTH` pins (eight by default) with a small register bus. Each pin can be driven by the port registers or handed to a peripheral. In port mode, an output register supplies the pin value and a direction register supplies the output enable. In peripheral mode, both come from a peripheral bus. Every pin input passes through a two-flop synchroniser. The synchronised value is what software reads and what edge detection uses.

Each pin has an interrupt flag, an edge-polarity bit and an enable bit. A transition of the chosen polarity on the synchronised input sets the flag. One interrupt line is high while any flag is set together with its enable. Software clears flags through the register bus.

Reads are combinational: `regRdData` shows the register selected by `regAddr` in the same cycle. Writes take effect at the rising clock edge on which `regWrEn` is high.

Top module: `gpio_port`

## Requirements
- R1: Register address 0 returns the synchronised pin levels (1 = high, 0 = low). A change on `pinIn` first shows there after the second rising clock edge that follows it.
- R2: For a pin whose select bit is 0, `pinOut` equals its output-register bit (address 1). `pinOe` equals its direction bit (address 2), where 1 means output and 0 means input (`pinOe` low).
- R3: For a pin whose select bit (address 3) is 1, `pinOut` and `pinOe` follow that pin's `periOut` and `periOe` bits.
- R4: A flag bit (address 4) is set by a transition of its synchronised input. An edge bit (address 5) of 0 selects low-to-high and 1 selects high-to-low. The flag is set on the third rising edge after the pin changes. A steady level never sets it.
- R5: A write to address 4 loads the written value into the flags, so 0 clears a flag and 1 sets it. If a qualifying edge and a write of 0 hit the same bit in the same cycle, the flag ends up 1.
- R6: `irq` is high exactly when some flag bit and the matching enable bit (address 6) are both 1. Each pin is enabled on its own.
- R7: Writes to address 0 and address 7 change no register. Address 7 reads as 0.
- R8: After reset, the output, direction, select, flag, edge and enable registers are all 0, so every pin is a port input with its interrupt off.
- R9: Addresses 1, 2, 3, 5 and 6 read back the last value written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 3 | Register address |
| regWrEn | input | 1 | Write strobe for the addressed register |
| regWrData | input | WIDTH | Write data |
| regRdData | output | WIDTH | Combinational read data of the addressed register |
| pinIn | input | WIDTH | Asynchronous levels from the pins |
| pinOut | output | WIDTH | Value to drive on each pin |
| pinOe | output | WIDTH | Output enable for each pin |
| periOut | input | WIDTH | Peripheral drive value per pin |
| periOe | input | WIDTH | Peripheral output enable per pin |
| irq | output | 1 | Combined interrupt request |

## Verification
The bench targets a flag write that lands in the same cycle as an edge. A design that lets the write win would lose the interrupt, and the flag would read 0 where 1 is due.

It also checks the exact synchroniser latency, with input reads and flag setting sampled cycle by cycle. A design with one stage too few or too many would show the new level or the flag a cycle early or late.

Further directed cases cover the following:
- Steady levels held for many cycles. A level-sensitive design would set the flag again after it was cleared.
- Falling-edge polarity.
- Writes to the input and reserved addresses. A design that decodes them would corrupt a neighbouring register.

Random traffic then mixes pin selection, peripheral drive and enables against a reference model.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_IN   = 3'd0,
    ADDR_OUT  = 3'd1,
    ADDR_DIR  = 3'd2,
    ADDR_SEL  = 3'd3,
    ADDR_FLAG = 3'd4,
    ADDR_EDGE = 3'd5,
    ADDR_IEN  = 3'd6,
    ADDR_RSVD = 3'd7
  } regAddr_e;

  typedef struct packed {
    logic wrOut;
    logic wrDir;
    logic wrSel;
    logic wrFlag;
    logic wrEdge;
    logic wrIen;
  } regStrobe_t;

endpackage

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
(
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output regStrobe_t        strobe,
  output regAddr_e          rdSel
);

  always_comb begin
    rdSel  = regAddr_e'(regAddr);
    strobe = '0;
    if (regWrEn) begin
      unique case (rdSel)
        ADDR_OUT:  strobe.wrOut  = 1'b1;
        ADDR_DIR:  strobe.wrDir  = 1'b1;
        ADDR_SEL:  strobe.wrSel  = 1'b1;
        ADDR_FLAG: strobe.wrFlag = 1'b1;
        ADDR_EDGE: strobe.wrEdge = 1'b1;
        ADDR_IEN:  strobe.wrIen  = 1'b1;
        default:   strobe        = '0;
      endcase
    end
  end

endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] stageQ [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stageQ[0] <= '0;
    else       stageQ[0] <= asyncIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stageQ[s] <= '0;
      else       stageQ[s] <= stageQ[s-1];
    end
  end

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/gpio_port_dp.sv
module gpio_port_dp
  import gpio_port_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  regStrobe_t       strobe,
  input  regAddr_e         rdSel,
  input  logic [WIDTH-1:0] wrData,
  input  logic [WIDTH-1:0] pinIn,
  input  logic [WIDTH-1:0] periOut,
  input  logic [WIDTH-1:0] periOe,
  output logic [WIDTH-1:0] rdData,
  output logic [WIDTH-1:0] pinOut,
  output logic [WIDTH-1:0] pinOe,
  output logic             irq,
  output logic [WIDTH-1:0] syncQ,
  output logic [WIDTH-1:0] prevQ,
  output logic [WIDTH-1:0] outQ,
  output logic [WIDTH-1:0] dirQ,
  output logic [WIDTH-1:0] selQ,
  output logic [WIDTH-1:0] flagQ,
  output logic [WIDTH-1:0] edgeQ,
  output logic [WIDTH-1:0] ienQ
);

  logic [WIDTH-1:0] edgeHit;
  logic [WIDTH-1:0] flagBase;

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (pinIn),
    .syncOut (syncQ)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevQ <= '0;
      outQ  <= '0;
      dirQ  <= '0;
      selQ  <= '0;
      flagQ <= '0;
      edgeQ <= '0;
      ienQ  <= '0;
    end else begin
      prevQ <= syncQ;
      if (strobe.wrOut)  outQ  <= wrData;
      if (strobe.wrDir)  dirQ  <= wrData;
      if (strobe.wrSel)  selQ  <= wrData;
      if (strobe.wrEdge) edgeQ <= wrData;
      if (strobe.wrIen)  ienQ  <= wrData;
      flagQ <= flagBase | edgeHit;
    end
  end

  assign flagBase = strobe.wrFlag ? wrData : flagQ;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic riseI;
    logic fallI;
    assign riseI      = syncQ[i] & ~prevQ[i];
    assign fallI      = ~syncQ[i] & prevQ[i];
    assign edgeHit[i] = edgeQ[i] ? fallI : riseI;
    assign pinOut[i]  = selQ[i] ? periOut[i] : outQ[i];
    assign pinOe[i]   = selQ[i] ? periOe[i]  : dirQ[i];
  end

  assign irq = |(flagQ & ienQ);

  always_comb begin
    unique case (rdSel)
      ADDR_IN:   rdData = syncQ;
      ADDR_OUT:  rdData = outQ;
      ADDR_DIR:  rdData = dirQ;
      ADDR_SEL:  rdData = selQ;
      ADDR_FLAG: rdData = flagQ;
      ADDR_EDGE: rdData = edgeQ;
      ADDR_IEN:  rdData = ienQ;
      default:   rdData = '0;
    endcase
  end

endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [WIDTH-1:0]  regWrData,
  output logic [WIDTH-1:0]  regRdData,
  input  logic [WIDTH-1:0]  pinIn,
  output logic [WIDTH-1:0]  pinOut,
  output logic [WIDTH-1:0]  pinOe,
  input  logic [WIDTH-1:0]  periOut,
  input  logic [WIDTH-1:0]  periOe,
  output logic              irq
);

  localparam int SYNC_STAGES = 2;

  regStrobe_t       strobe;
  regAddr_e         rdSel;
  logic [WIDTH-1:0] syncQ, prevQ, outQ, dirQ, selQ, flagQ, edgeQ, ienQ;

  gpio_port_ctrl u_ctrl (
    .regAddr (regAddr),
    .regWrEn (regWrEn),
    .strobe  (strobe),
    .rdSel   (rdSel)
  );

  gpio_port_dp #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .rdSel   (rdSel),
    .wrData  (regWrData),
    .pinIn   (pinIn),
    .periOut (periOut),
    .periOe  (periOe),
    .rdData  (regRdData),
    .pinOut  (pinOut),
    .pinOe   (pinOe),
    .irq     (irq),
    .syncQ   (syncQ),
    .prevQ   (prevQ),
    .outQ    (outQ),
    .dirQ    (dirQ),
    .selQ    (selQ),
    .flagQ   (flagQ),
    .edgeQ   (edgeQ),
    .ienQ    (ienQ)
  );

endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic [2:0]       regAddr,
  input logic             regWrEn,
  input logic             irq,
  input logic [WIDTH-1:0] syncQ,
  input logic [WIDTH-1:0] prevQ,
  input logic [WIDTH-1:0] outQ,
  input logic [WIDTH-1:0] dirQ,
  input logic [WIDTH-1:0] selQ,
  input logic [WIDTH-1:0] flagQ,
  input logic [WIDTH-1:0] edgeQ,
  input logic [WIDTH-1:0] ienQ
);

  logic             flagWrite;
  logic             inWrite;
  logic [WIDTH-1:0] hitC;

  assign flagWrite = regWrEn && (regAddr == 3'd4);
  assign inWrite   = regWrEn && (regAddr == 3'd0);
  assign hitC      = (edgeQ & ~syncQ & prevQ) | (~edgeQ & syncQ & ~prevQ);

  // R4: without a flag write, a flag only rises where an edge was seen
  a_r4_flag_from_edge_only: assert property (@(posedge clk) disable iff (!rstN)
    !$past(flagWrite) |-> ((flagQ & ~$past(flagQ) & ~$past(hitC)) == '0));

  // R5: an edge beats a simultaneous software write
  a_r5_edge_beats_write: assert property (@(posedge clk) disable iff (!rstN)
    $past(flagWrite) |-> (($past(hitC) & ~flagQ) == '0));

  // R6: the interrupt needs an enabled pending flag
  a_r6_irq_needs_enabled_flag: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> ((flagQ & ienQ) != '0));

  // R7: writing the input address leaves configuration untouched
  a_r7_input_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    $past(inWrite) |-> ($stable(outQ) && $stable(dirQ) && $stable(selQ) &&
                        $stable(edgeQ) && $stable(ienQ)));

  // R8: configuration is cleared when reset is released
  a_r8_reset_state: assert property (@(posedge clk)
    $rose(rstN) |-> (outQ == '0 && dirQ == '0 && selQ == '0 &&
                     flagQ == '0 && edgeQ == '0 && ienQ == '0));

endmodule

bind gpio_port gpio_port_chk #(.WIDTH(WIDTH)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .regAddr (regAddr),
  .regWrEn (regWrEn),
  .irq     (irq),
  .syncQ   (syncQ),
  .prevQ   (prevQ),
  .outQ    (outQ),
  .dirQ    (dirQ),
  .selQ    (selQ),
  .flagQ   (flagQ),
  .edgeQ   (edgeQ),
  .ienQ    (ienQ)
);

// File: tb/gpio_port_tb.sv
`timescale 1ns/1ps
module gpio_port_tb;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [2:0]   regAddr = '0;
  logic         regWrEn = 1'b0;
  logic [W-1:0] regWrData = '0;
  logic [W-1:0] regRdData;
  logic [W-1:0] pinIn = '0;
  logic [W-1:0] pinOut, pinOe;
  logic [W-1:0] periOut = '0;
  logic [W-1:0] periOe = '0;
  logic         irq;

  int tests = 0;
  int fails = 0;

  logic [W-1:0] mS1 = '0, mS2 = '0, mPrev = '0;
  logic [W-1:0] mOut = '0, mDir = '0, mSel = '0, mFlag = '0, mEdge = '0, mIen = '0;
  logic [W-1:0] curPins = '0;

  always #4 clk = ~clk;

  gpio_port #(.WIDTH(W)) u_dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .periOut(periOut), .periOe(periOe), .irq(irq)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [W-1:0] expRead(input logic [2:0] a);
    case (a)
      3'd0: return mS2;
      3'd1: return mOut;
      3'd2: return mDir;
      3'd3: return mSel;
      3'd4: return mFlag;
      3'd5: return mEdge;
      3'd6: return mIen;
      default: return '0;
    endcase
  endfunction

  function automatic string readTag(input logic [2:0] a);
    case (a)
      3'd0: return "R1";
      3'd4: return "R4";
      3'd7: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic cyc(input logic we, input logic [2:0] a, input logic [W-1:0] d,
                     input logic [W-1:0] pins, input logic [W-1:0] po, input logic [W-1:0] poe,
                     input logic hasExp, input logic [W-1:0] expVal, input string expTag);
    logic [W-1:0] hit, nFlag;
    @(negedge clk);
    regWrEn = we; regAddr = a; regWrData = d; pinIn = pins; periOut = po; periOe = poe;
    #1;
    chk(readTag(a), regRdData, expRead(a));
    chk((mSel == '0) ? "R2" : ((mSel == '1) ? "R3" : "R2 R3"), pinOut, (mSel & po) | (~mSel & mOut));
    chk((mSel == '0) ? "R2" : ((mSel == '1) ? "R3" : "R2 R3"), pinOe, (mSel & poe) | (~mSel & mDir));
    chk("R6", {{(W-1){1'b0}}, irq}, {{(W-1){1'b0}}, |(mFlag & mIen)});
    if (hasExp) chk(expTag, regRdData, expVal);
    @(posedge clk);
    hit   = (mEdge & ~mS2 & mPrev) | (~mEdge & mS2 & ~mPrev);
    nFlag = ((we && a == 3'd4) ? d : mFlag) | hit;
    mFlag = nFlag;
    mPrev = mS2; mS2 = mS1; mS1 = pins;
    if (we) begin
      case (a)
        3'd1: mOut  = d;
        3'd2: mDir  = d;
        3'd3: mSel  = d;
        3'd5: mEdge = d;
        3'd6: mIen  = d;
        default: ;
      endcase
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    cyc(1'b1, a, d, curPins, '0, '0, 1'b0, '0, "");
  endtask

  task automatic rd(input logic [2:0] a, input logic [W-1:0] e, input string tag);
    cyc(1'b0, a, '0, curPins, '0, '0, 1'b1, e, tag);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc(1'b0, 3'd1, '0, curPins, '0, '0, 1'b0, '0, "");
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R8 reset state
    rd(3'd1, 8'h00, "R8"); rd(3'd2, 8'h00, "R8"); rd(3'd3, 8'h00, "R8");
    rd(3'd4, 8'h00, "R8"); rd(3'd5, 8'h00, "R8"); rd(3'd6, 8'h00, "R8");

    // R9 readback
    wr(3'd1, 8'h3c); wr(3'd2, 8'hf0); wr(3'd3, 8'h00); wr(3'd5, 8'h00); wr(3'd6, 8'h00);
    rd(3'd1, 8'h3c, "R9"); rd(3'd2, 8'hf0, "R9");

    // R7 ignored writes
    wr(3'd0, 8'hff); wr(3'd7, 8'hff);
    rd(3'd7, 8'h00, "R7"); rd(3'd1, 8'h3c, "R7"); rd(3'd2, 8'hf0, "R7");

    // R1 synchroniser latency
    curPins = 8'ha5;
    rd(3'd0, 8'h00, "R1"); rd(3'd0, 8'h00, "R1"); rd(3'd0, 8'ha5, "R1");

    // R4 steady level never re-sets a cleared flag
    idle(4); wr(3'd4, 8'h00); idle(10); rd(3'd4, 8'h00, "R4");

    // R4 falling edge on bit 0
    wr(3'd5, 8'h01); curPins = 8'ha4; idle(3); rd(3'd4, 8'h01, "R4");
    wr(3'd4, 8'h00); rd(3'd4, 8'h00, "R5");

    // R5 edge wins over same-cycle clear, on bit 1 rising
    curPins = 8'ha6; idle(2); wr(3'd4, 8'h00); rd(3'd4, 8'h02, "R5");

    // R6 per-bit enable
    wr(3'd6, 8'h01); idle(1); wr(3'd6, 8'h02); idle(1); wr(3'd4, 8'h00); idle(2);

    // R3 peripheral mode with random drive
    wr(3'd3, 8'hff);
    for (int k = 0; k < 8; k++)
      cyc(1'b0, 3'd3, '0, curPins, W'($urandom), W'($urandom), 1'b0, '0, "");

    // random mix
    for (int k = 0; k < 600; k++) begin
      logic [2:0] a;
      logic we;
      a  = 3'($urandom_range(0, 7));
      we = ($urandom_range(0, 2) == 0);
      if ($urandom_range(0, 3) == 0) curPins = W'($urandom);
      cyc(we, a, W'($urandom), curPins, W'($urandom), W'($urandom), 1'b0, '0, "");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule